// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

This block is a synchronous up-counter with a parameterised width (four bits by default, so sixteen states). Every state change happens on the rising clock edge. On each edge the block does one of four things, in a fixed priority order: it clears the count to zero, loads a parallel data word, advances by one, or holds. An active-low clear input selects the first action and an active-low load input selects the second. Counting needs two enable inputs at once. One is a plain step enable. The other is a carry-chain enable, and it also gates the carry output.

The carry output is combinational. It is high only while the count sits at its all-ones terminal value and the carry-chain enable is high. A wider counter is built by feeding this output into the carry-chain enable of the next stage. There is no separate reset: the count is defined only after the first edge at which clear is held low.

Top module: `bin_preset_counter`

## Requirements
- R1: With clearN and loadN high (1) and both stepEnable and chainEnable high (1), each rising edge adds one to the count. The count moves 0, 1, ..., 15 and wraps from 15 back to 0, giving sixteen states.
- R2: clearN low (0) at a rising edge sets the count to 0, whatever loadN, the enables and loadData are. Clear therefore takes priority over both load and count.
- R3: With clearN high, loadN low (0) at a rising edge copies loadData into the count, whatever the state of the two enables. Load therefore takes priority over counting.
- R4: With clearN and loadN high, the count holds its value across an edge when stepEnable or chainEnable is low (0).
- R5: carryOut is high (1) exactly when chainEnable is high and the count equals 15 (all ones). It is combinational: it follows chainEnable without waiting for a clock edge.
- R6: A load of 12 followed by counting with both enables high gives the counts 12, 13, 14, 15, 0, 1, 2. carryOut is high only while the count is 15.
- R7: Holding the count at 15 with stepEnable high and chainEnable low keeps carryOut low. The count stays at 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all state |
| clearN | input | 1 | Active-low synchronous clear, highest priority |
| loadN | input | 1 | Active-low synchronous parallel load |
| stepEnable | input | 1 | Step enable; gates counting only |
| chainEnable | input | 1 | Carry-chain enable; gates counting and carryOut |
| loadData | input | WIDTH | Word copied into the count on load |
| count | output | WIDTH | Present count |
| carryOut | output | 1 | Terminal-count carry, gated by chainEnable |

## Verification
Clear, load and count can all be asserted in the same cycle. The stimulus does this on purpose with random control bits, including clear or load arriving while both enables are high and the count sits at 15. The expected outcome follows the priority order: clear wins over load, and load wins over counting. A bench model derives that outcome from the requirements and compares it with the count sampled after the edge. The same random and directed cycles also check carryOut against the chain enable while the count is at 15, one time step after the enables change and before the next clock edge.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  // Per-edge action selected by the control; at most one strobe is high.
  typedef struct packed {
    logic clearStb;
    logic loadStb;
    logic stepStb;
  } ctrStrobes_t;
endpackage

// File: rtl/ctr_control.sv
module ctr_control
  import ctr_pkg::*;
(
  input  logic        clearN,
  input  logic        loadN,
  input  logic        stepEnable,
  input  logic        chainEnable,
  output ctrStrobes_t strobes
);
  // Priority: clear over load over step.
  always_comb begin
    strobes = '0;
    if (!clearN)                        strobes.clearStb = 1'b1;
    else if (!loadN)                    strobes.loadStb  = 1'b1;
    else if (stepEnable && chainEnable) strobes.stepStb  = 1'b1;
  end
endmodule

// File: rtl/ctr_datapath.sv
module ctr_datapath
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  ctrStrobes_t      strobes,
  input  logic             chainEnable,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);
  localparam logic [WIDTH-1:0] TermCount = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] OneStep   = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] countReg;
  logic [WIDTH-1:0] countNext;
  logic             atTerminal;

  always_comb begin
    countNext = countReg;
    if (strobes.clearStb)     countNext = '0;
    else if (strobes.loadStb) countNext = loadData;
    else if (strobes.stepStb) countNext = countReg + OneStep;
  end

  always_ff @(posedge clk) begin
    countReg <= countNext;
  end

  assign atTerminal = (countReg == TermCount);
  assign carryOut   = chainEnable & atTerminal;
  assign count      = countReg;
endmodule

// File: rtl/bin_preset_counter.sv
module bin_preset_counter
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             loadN,
  input  logic             stepEnable,
  input  logic             chainEnable,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);
  ctrStrobes_t strobes;

  ctr_control u_ctrl (
    .clearN      (clearN),
    .loadN       (loadN),
    .stepEnable  (stepEnable),
    .chainEnable (chainEnable),
    .strobes     (strobes)
  );

  ctr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk         (clk),
    .strobes     (strobes),
    .chainEnable (chainEnable),
    .loadData    (loadData),
    .count       (count),
    .carryOut    (carryOut)
  );
endmodule

// File: rtl/ctr_checker.sv
module ctr_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clearN,
  input logic             loadN,
  input logic             stepEnable,
  input logic             chainEnable,
  input logic [WIDTH-1:0] loadData,
  input logic [WIDTH-1:0] count,
  input logic             carryOut
);
  localparam logic [WIDTH-1:0] TermCount = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] OneStep   = {{(WIDTH-1){1'b0}}, 1'b1};

  // Count is undefined until the first clear; checks start after it.
  logic primed = 1'b0;
  always_ff @(posedge clk) begin
    if (!clearN) primed <= 1'b1;
  end

  assert_clear_wins_R2: assert property (@(posedge clk) disable iff (!primed)
    !clearN |=> (count == '0));

  assert_load_copies_R3: assert property (@(posedge clk) disable iff (!primed)
    (clearN && !loadN) |=> (count == $past(loadData)));

  assert_hold_when_gated_R4: assert property (@(posedge clk) disable iff (!primed)
    (clearN && loadN && !(stepEnable && chainEnable)) |=> $stable(count));

  assert_step_wraps_R1: assert property (@(posedge clk) disable iff (!primed)
    (clearN && loadN && stepEnable && chainEnable) |=> (count == $past(count) + OneStep));

  assert_carry_gated_R5: assert property (@(posedge clk) disable iff (!primed)
    carryOut == (chainEnable && (count == TermCount)));

  assert_carry_off_chain_low_R7: assert property (@(posedge clk) disable iff (!primed)
    !chainEnable |-> !carryOut);
endmodule

bind bin_preset_counter ctr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .clearN      (clearN),
  .loadN       (loadN),
  .stepEnable  (stepEnable),
  .chainEnable (chainEnable),
  .loadData    (loadData),
  .count       (count),
  .carryOut    (carryOut)
);

// File: tb/bin_preset_counter_bench.sv
`timescale 1ns/1ps
module bin_preset_counter_bench;
  localparam int WIDTH = 4;
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic             clk = 1'b0;
  logic             clearN = 1'b1;
  logic             loadN = 1'b1;
  logic             stepEnable = 1'b0;
  logic             chainEnable = 1'b0;
  logic [WIDTH-1:0] loadData = '0;
  logic [WIDTH-1:0] count;
  logic             carryOut;

  int checks = 0;
  int fails  = 0;
  logic [WIDTH-1:0] model;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bin_preset_counter #(.WIDTH(WIDTH)) u_bin_preset_counter (
    .clk(clk), .clearN(clearN), .loadN(loadN), .stepEnable(stepEnable),
    .chainEnable(chainEnable), .loadData(loadData), .count(count), .carryOut(carryOut)
  );

  // Next count from requirements R1..R4.
  function automatic logic [WIDTH-1:0] expectNext(logic [WIDTH-1:0] cur, logic c, logic l,
                                                  logic s, logic t, logic [WIDTH-1:0] d);
    if (!c) return '0;
    if (!l) return d;
    if (s && t) return cur + 1'b1;
    return cur;
  endfunction

  function automatic logic expectCarry(logic [WIDTH-1:0] cur, logic t);
    return t && (cur == TOP);
  endfunction

  task automatic check(string req, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive at negedge, check carry before the edge, count after it.
  task automatic cycle(string req, logic c, logic l, logic s, logic t, logic [WIDTH-1:0] d);
    @(negedge clk);
    clearN = c; loadN = l; stepEnable = s; chainEnable = t; loadData = d;
    #1;
    check("R5 carry", {{(WIDTH-1){1'b0}}, carryOut}, {{(WIDTH-1){1'b0}}, expectCarry(model, t)});
    @(posedge clk);
    model = expectNext(model, c, l, s, t, d);
    #2;
    check(req, count, model);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model = 'x;
    // Reset state via clear, with load and enables also active (R2).
    cycle("R2 clear over load and step", 1'b0, 1'b0, 1'b1, 1'b1, 4'd9);
    check("R2 reset state", count, 4'd0);

    // Preset 12 then count: 12,13,14,15,0,1,2 (R6), carry only at 15.
    cycle("R6 preset 12", 1'b1, 1'b0, 1'b0, 1'b0, 4'd12);
    for (int i = 0; i < 6; i++) cycle("R6 sequence", 1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
    check("R6 end at 2", count, 4'd2);

    // Full wrap over sixteen steps (R1).
    for (int i = 0; i < 16; i++) cycle("R1 count", 1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
    check("R1 wrap back to 2", count, 4'd2);

    // Hold when either enable is low (R4).
    cycle("R4 hold step low", 1'b1, 1'b1, 1'b0, 1'b1, 4'd7);
    cycle("R4 hold chain low", 1'b1, 1'b1, 1'b1, 1'b0, 4'd7);
    cycle("R4 hold both low", 1'b1, 1'b1, 1'b0, 1'b0, 4'd7);

    // Load ignores enables (R3) and beats step.
    cycle("R3 load over step", 1'b1, 1'b0, 1'b1, 1'b1, 4'd15);
    // At 15, chain low: carry low and count holds (R7).
    cycle("R7 hold at 15 chain low", 1'b1, 1'b1, 1'b1, 1'b0, 4'd3);
    check("R7 count still 15", count, 4'd15);
    // Clear at terminal count with all else active (R2).
    cycle("R2 clear at 15", 1'b0, 1'b0, 1'b1, 1'b1, 4'd5);

    // Constrained random with fixed seed.
    void'($urandom(32'd20240611));
    for (int i = 0; i < 400; i++) begin
      logic c, l, s, t;
      logic [WIDTH-1:0] d;
      c = ($urandom_range(0, 15) != 0);
      l = ($urandom_range(0, 5) != 0);
      s = ($urandom_range(0, 3) != 0);
      t = ($urandom_range(0, 3) != 0);
      d = WIDTH'($urandom_range(0, 15));
      cycle("R1 R2 R3 R4 random", c, l, s, t, d);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule